// File: doc/BRIEF.md
# Serial BCD Offset Adder-Subtractor

This block sits on a bit-serial decimal measurement path just before the result is stored. Each stream carries a fixed number of BCD digits. Every digit is sent as four bits, least significant bit first, and the digits themselves arrive least significant first. In direct mode the digits leave exactly as they came in. In offset mode one constant BCD digit, supplied from outside, is added to or subtracted from the value at a single decade set by a parameter. This removes or restores a fixed intermediate-frequency offset. Decimal correction is applied within each digit, and a carry or borrow ripples upward through the remaining digits.

Internally, four input bits are gathered into a digit. The digit goes through a single decimal adder that also handles subtraction by nines' complement. The result is then shifted out again, one bit per cycle. A pending carry or borrow is held in a flip-flop from one digit to the next. Mode, operation and constant are captured on the first bit of each stream. A flag reports when a subtraction runs below zero.

Top module: `bcd_serial_offset`

## Requirements
- R1: After synchronous reset, `m_valid`, `m_sop`, `m_last` and `underflow` are all 0.
- R2: A stream is NUM_DIGITS digits of 4 bits each, with bits LSB first and digits least significant first. `s_sop` marks the stream's first bit. Each output digit appears on 4 consecutive cycles, starting the cycle after its fourth input bit is accepted. `m_sop` flags the first output bit of a stream and `m_last` flags its final bit.
- R3: With `mode_offset`=0, every output digit equals its input digit bit-for-bit, including codes 10 to 15. `op_sub` and `k_digit` have no effect.
- R4: With `mode_offset`=1 and `op_sub`=0, the output is (input + K·10^OFFSET_POS) mod 10^NUM_DIGITS in valid BCD. Any digit sum above 9 is corrected and produces a carry.
- R5: With `mode_offset`=1 and `op_sub`=1, the output is input − K·10^OFFSET_POS. A negative result wraps by adding 10^NUM_DIGITS.
- R6: `underflow` goes to 1 after the final digit of an offset subtraction that borrows out of the top digit. It returns to 0 the cycle after the next `s_sop` bit. Add and direct streams never set it.
- R7: The carry or borrow is cleared at every `s_sop`, so a stream's result never depends on the stream before it.
- R8: `mode_offset`, `op_sub` and `k_digit` are sampled only on the `s_sop` bit. Changing them later in the stream has no effect.
- R9: Cycles with `s_valid`=0 are idle, and gaps between bits do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input bit present |
| s_data | input | 1 | Input serial BCD bit |
| s_sop | input | 1 | First bit of a stream |
| mode_offset | input | 1 | 1 = apply offset, 0 = pass through |
| op_sub | input | 1 | 1 = subtract constant, 0 = add |
| k_digit | input | 4 | BCD constant digit |
| m_valid | output | 1 | Output bit present |
| m_data | output | 1 | Output serial BCD bit |
| m_sop | output | 1 | First output bit of a stream |
| m_last | output | 1 | Final output bit of a stream |
| underflow | output | 1 | Last subtraction borrowed past the top digit |

## Verification
The hardest cases to reach are a borrow or carry that has to ripple through every digit above the offset decade, and the wrap past zero that raises `underflow`. Both only happen for particular input values. The bench reaches them with a small configuration (three digits, offset at the tens digit) and sweeps all 1000 input values through both add and subtract. A second sweep varies the constant over 0 to 9 with idle gaps inserted between bits. Further streams change the configuration inputs mid-stream and feed invalid nibbles through direct mode.

// File: rtl/bcd_sa_pkg.sv
package bcd_sa_pkg;
  typedef logic [3:0] bcd_t;
endpackage

// File: rtl/bcd_sa_digit_alu.sv
module bcd_sa_digit_alu
  import bcd_sa_pkg::*;
(
  input  bcd_t a,
  input  bcd_t b,
  input  logic sub,
  input  logic cin,
  output bcd_t y,
  output logic cout
);
  bcd_t       b_eff;
  logic [4:0] raw;
  logic [4:0] fixed;

  always_comb begin
    b_eff = sub ? (4'd9 - b) : b;
    raw   = {1'b0, a} + {1'b0, b_eff} + {4'b0, cin};
    fixed = raw - 5'd10;
    if (raw > 5'd9) begin
      y    = fixed[3:0];
      cout = 1'b1;
    end else begin
      y    = raw[3:0];
      cout = 1'b0;
    end
  end
endmodule

// File: rtl/bcd_sa_ingest.sv
module bcd_sa_ingest
  import bcd_sa_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic s_valid,
  input  logic s_data,
  input  logic s_sop,
  output logic done,
  output bcd_t digit
);
  logic [1:0] cnt;
  logic [2:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= 2'd0;
      hold <= 3'd0;
    end else if (s_valid) begin
      if (s_sop) begin
        cnt  <= 2'd1;
        hold <= {s_data, 2'b00};
      end else begin
        cnt  <= cnt + 2'd1;
        hold <= {s_data, hold[2:1]};
      end
    end
  end

  assign done  = s_valid && !s_sop && (cnt == 2'd3);
  assign digit = {s_data, hold};
endmodule

// File: rtl/bcd_sa_serializer.sv
module bcd_sa_serializer
  import bcd_sa_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  bcd_t       ld_digit,
  input  logic       ld_first,
  input  logic       ld_last,
  output logic       m_valid,
  output logic       m_data,
  output logic       m_sop,
  output logic       m_last,
  output logic [1:0] left
);
  logic [2:0] rest;
  logic       last_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid   <= 1'b0;
      m_data    <= 1'b0;
      m_sop     <= 1'b0;
      m_last    <= 1'b0;
      rest      <= 3'd0;
      left      <= 2'd0;
      last_flag <= 1'b0;
    end else if (load) begin
      m_valid   <= 1'b1;
      m_data    <= ld_digit[0];
      m_sop     <= ld_first;
      m_last    <= 1'b0;
      rest      <= ld_digit[3:1];
      left      <= 2'd3;
      last_flag <= ld_last;
    end else if (left != 2'd0) begin
      m_valid   <= 1'b1;
      m_data    <= rest[0];
      m_sop     <= 1'b0;
      m_last    <= last_flag && (left == 2'd1);
      rest      <= {1'b0, rest[2:1]};
      left      <= left - 2'd1;
    end else begin
      m_valid   <= 1'b0;
      m_sop     <= 1'b0;
      m_last    <= 1'b0;
    end
  end
endmodule

// File: rtl/bcd_serial_offset.sv
module bcd_serial_offset
  import bcd_sa_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int OFFSET_POS = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       s_valid,
  input  logic       s_data,
  input  logic       s_sop,
  input  logic       mode_offset,
  input  logic       op_sub,
  input  logic [3:0] k_digit,
  output logic       m_valid,
  output logic       m_data,
  output logic       m_sop,
  output logic       m_last,
  output logic       underflow
);
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIGITS - 1);
  localparam logic [IDX_W-1:0] OFS_IDX  = IDX_W'(OFFSET_POS);

  logic             done;
  bcd_t             digit_in;
  logic             cfg_off, cfg_sub;
  bcd_t             cfg_k;
  logic             active;
  logic [IDX_W-1:0] dig_idx;
  logic             pend;
  bcd_t             operand, alu_y, ld_digit;
  logic             alu_cin, alu_cout, pend_next;
  logic             ld, ld_first, ld_last;
  logic [1:0]       ser_left;

  bcd_sa_ingest u_ingest (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data),
    .s_sop(s_sop), .done(done), .digit(digit_in)
  );

  always_comb begin
    operand   = (cfg_off && dig_idx == OFS_IDX) ? cfg_k : 4'd0;
    alu_cin   = cfg_sub ? !pend : pend;
    pend_next = cfg_sub ? !alu_cout : alu_cout;
    ld_digit  = cfg_off ? alu_y : digit_in;
    ld        = done && active;
    ld_first  = (dig_idx == '0);
    ld_last   = (dig_idx == LAST_IDX);
  end

  bcd_sa_digit_alu u_alu (
    .a(digit_in), .b(operand), .sub(cfg_sub), .cin(alu_cin),
    .y(alu_y), .cout(alu_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_off   <= 1'b0;
      cfg_sub   <= 1'b0;
      cfg_k     <= 4'd0;
      active    <= 1'b0;
      dig_idx   <= '0;
      pend      <= 1'b0;
      underflow <= 1'b0;
    end else if (s_valid && s_sop) begin
      cfg_off   <= mode_offset;
      cfg_sub   <= op_sub;
      cfg_k     <= k_digit;
      active    <= 1'b1;
      dig_idx   <= '0;
      pend      <= 1'b0;
      underflow <= 1'b0;
    end else if (ld) begin
      pend    <= pend_next;
      dig_idx <= dig_idx + 1'b1;
      if (ld_last) begin
        active    <= 1'b0;
        underflow <= cfg_off && cfg_sub && pend_next;
      end
    end
  end

  bcd_sa_serializer u_ser (
    .clk(clk), .rst(rst), .load(ld), .ld_digit(ld_digit),
    .ld_first(ld_first), .ld_last(ld_last),
    .m_valid(m_valid), .m_data(m_data), .m_sop(m_sop),
    .m_last(m_last), .left(ser_left)
  );
endmodule

// File: rtl/bcd_serial_offset_chk.sv
module bcd_serial_offset_chk (
  input logic       clk,
  input logic       rst,
  input logic       s_valid,
  input logic       s_sop,
  input logic       m_valid,
  input logic       m_sop,
  input logic       m_last,
  input logic       underflow,
  input logic       cfg_off,
  input logic       cfg_sub,
  input logic       ld,
  input logic [1:0] ser_left
);
  assert_sop_valid_R2: assert property (@(posedge clk) disable iff (rst)
    m_sop |-> m_valid);
  assert_last_valid_R2: assert property (@(posedge clk) disable iff (rst)
    m_last |-> m_valid);
  assert_uf_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_sop) |=> !underflow);
  assert_uf_sub_only_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(underflow) |-> (cfg_off && cfg_sub));
  assert_load_spacing_R9: assert property (@(posedge clk) disable iff (rst)
    ld |-> (ser_left <= 2'd1));
endmodule

bind bcd_serial_offset bcd_serial_offset_chk chk_i (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_sop(s_sop),
  .m_valid(m_valid), .m_sop(m_sop), .m_last(m_last), .underflow(underflow),
  .cfg_off(cfg_off), .cfg_sub(cfg_sub), .ld(ld), .ser_left(ser_left)
);

// File: tb/bcd_serial_offset_tb.sv
module bcd_serial_offset_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 3;
  localparam int POS = 1;
  localparam int W   = 4 * N;
  localparam int MOD = 1000;
  localparam int PW  = 10;

  logic clk = 0, rst = 1;
  logic s_valid = 0, s_data = 0, s_sop = 0;
  logic mode_offset = 0, op_sub = 0;
  logic [3:0] k_digit = 0;
  logic m_valid, m_data, m_sop, m_last, underflow;

  int checks = 0, fails = 0;
  logic [W-1:0] cap;
  int idx = 0, last_idx = -1;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_serial_offset #(.NUM_DIGITS(N), .OFFSET_POS(POS)) dut_i (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data), .s_sop(s_sop),
    .mode_offset(mode_offset), .op_sub(op_sub), .k_digit(k_digit),
    .m_valid(m_valid), .m_data(m_data), .m_sop(m_sop), .m_last(m_last),
    .underflow(underflow)
  );

  always @(negedge clk) begin
    if (m_valid) begin
      if (m_sop) begin
        cap = '0;
        idx = 0;
        last_idx = -1;
      end
      if (idx < W) cap[idx] = m_data;
      if (m_last) last_idx = idx;
      idx = idx + 1;
    end
  end

  function automatic logic [W-1:0] to_bcd(input int v);
    logic [W-1:0] r = '0;
    int x = v;
    for (int d = 0; d < N; d++) begin
      r[4*d +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] word, input logic off, input logic sub,
                      input logic [3:0] k, input bit gaps, input bit flip);
    for (int b = 0; b < W; b++) begin
      s_valid = 1; s_data = word[b]; s_sop = (b == 0);
      if (b == 0) begin
        mode_offset = off; op_sub = sub; k_digit = k;
      end else if (flip) begin
        mode_offset = ~off; op_sub = ~sub; k_digit = 4'd9 - k;
      end
      @(negedge clk);
      if (b == 0) check("R6 clear at sop", W'(underflow), W'(0));
      if (gaps && (b % 3 == 1)) begin
        s_valid = 0; s_data = ~s_data; s_sop = 1;
        @(negedge clk);
      end
    end
    s_valid = 0; s_sop = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic run(input int v, input logic off, input logic sub,
                     input logic [3:0] k, input bit gaps, input bit flip, input string req);
    int e;
    logic euf;
    e = v; euf = 0;
    if (off && !sub) e = (v + k * PW) % MOD;
    if (off && sub) begin
      e = v - k * PW;
      if (e < 0) begin e = e + MOD; euf = 1; end
    end
    send(to_bcd(v), off, sub, k, gaps, flip);
    check(req, cap, to_bcd(e));
    check("R6 underflow", W'(underflow), W'(euf));
    check("R2 last index", W'(last_idx), W'(W - 1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset outputs", W'({m_valid, m_sop, m_last, underflow}), W'(0));

    // R4 R5 R7: full sweep, back to back, offset constant 2
    for (int v = 0; v < MOD; v++) begin
      run(v, 1'b1, 1'b0, 4'd2, 1'b0, 1'b0, "R4 add");
      run(v, 1'b1, 1'b1, 4'd2, 1'b0, 1'b0, "R5 sub");
    end
    // R9: constant sweep with idle gaps
    for (int v = 0; v < MOD; v += 37)
      for (int k = 0; k < 10; k++) begin
        run(v, 1'b1, 1'b0, 4'(k), 1'b1, 1'b0, "R9 gapped add");
        run(v, 1'b1, 1'b1, 4'(k), 1'b1, 1'b0, "R9 gapped sub");
      end
    // R3: direct mode, op and constant ignored
    for (int v = 0; v < MOD; v += 53)
      run(v, 1'b0, v[0], 4'(v % 10), 1'b0, 1'b0, "R3 direct");
    // R3: invalid nibbles pass untouched
    for (int j = 0; j < 16; j++) begin
      logic [W-1:0] w = {4'(j), 4'(15 - j), 4'hF};
      send(w, 1'b0, 1'b1, 4'd7, 1'b0, 1'b0);
      check("R3 raw nibbles", cap, w);
      check("R6 direct no underflow", W'(underflow), W'(0));
    end
    // R8: config changes after the sop bit have no effect
    run(5, 1'b1, 1'b1, 4'd2, 1'b0, 1'b1, "R8 mid-stream change sub");
    run(123, 1'b1, 1'b0, 4'd8, 1'b0, 1'b1, "R8 mid-stream change add");
    run(456, 1'b0, 1'b0, 4'd3, 1'b0, 1'b1, "R8 mid-stream change direct");
    // R7: stream after an underflow starts clean
    run(0, 1'b1, 1'b1, 4'd9, 1'b0, 1'b0, "R5 wrap");
    run(999, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, "R7 clean after borrow");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule